// File: doc/BRIEF.md
# One-Time-Programmable Fuse Access Sequencer

This block drives an asynchronous 256-bit fuse array that is arranged as 32 bytes. A requester asks, through a single-cycle request, for either a byte read or the blowing of one fuse bit. The sequencer then steps the array's select, sense-latch, strobe and program-enable pins through a fixed order. It counts clock cycles itself so that every gap between control edges, and the program pulse, has a known length. The array has no clock, so no edge may rely on the array's own timing.

All gap lengths come from a clock-frequency parameter (`CLK_MHZ`) together with nanosecond parameters. The setup and hold gap is `GAP_CYC = ceil(GAP_NS*CLK_MHZ/1000)`, which is 5 cycles by default. The program pulse is `PGM_CYC = PGM_NS*CLK_MHZ/1000`, which is 2500 cycles (10 µs) by default. Programming is guarded by a key register: a request to blow a fuse while the guard is locked is refused with an error and leaves the array untouched.

State machine states: `ST_IDLE`, `ST_RD_SEL`, `ST_RD_LOAD`, `ST_RD_STRB`, `ST_RD_CAPT`, `ST_PG_SEL`, `ST_PG_PULSE`, `ST_PG_HOLD`, `ST_FINISH`, `ST_REJECT`.

Transitions:
- `ST_IDLE` goes to `ST_RD_SEL` on a read request, to `ST_PG_SEL` on a program request while unlocked, and to `ST_REJECT` on a program request while locked.
- The read path steps `ST_RD_SEL` → `ST_RD_LOAD` → `ST_RD_STRB` → `ST_RD_CAPT` → `ST_FINISH`, each step taken on timer expiry.
- The program path steps `ST_PG_SEL` → `ST_PG_PULSE` → `ST_PG_HOLD` → `ST_FINISH`, each step taken on timer expiry.
- `ST_FINISH` and `ST_REJECT` both return to `ST_IDLE` after one cycle.

Top module: `fuse_seq_ctrl`

## Requirements
- R1: While and after reset: busy=0, done=0, err=0, rd_data=0, fz_csb_n=1, fz_strobe=0, fz_load=0, fz_pgm_n=1, and the guard is locked.
- R2: A read request taken in idle selects the array (fz_csb_n=0) with fz_addr = {req_addr[7:3],3'b000}. After GAP_CYC cycles fz_load rises. After GAP_CYC more cycles fz_strobe is high for GAP_CYC cycles. fz_load and select are then held for GAP_CYC cycles. done follows 4*GAP_CYC+1 cycles after the request edge.
- R3: After a read, bit i of rd_data equals fuse bit 8*req_addr[7:3]+i. rd_data keeps that value until the next read completes.
- R4: An accepted program request drives fz_csb_n=0, fz_pgm_n=0 and fz_addr=req_addr (the fuse bit index). fz_strobe rises after GAP_CYC cycles and stays high for exactly PGM_CYC cycles. Select and program-enable are held for GAP_CYC more cycles. done follows 2*GAP_CYC+PGM_CYC+1 cycles after the request edge.
- R5: A key write with key_data equal to KEY (default 8'hA5) unlocks the guard. A key write with any other value locks it.
- R6: A program request while locked causes no activity on any array pin. done and err are both 1 for one cycle, one cycle after the request.
- R7: Reads are served whether the guard is locked or unlocked.
- R8: A request made while busy=1 is ignored: no second done, and no fuse is blown.
- R9: done is a single-cycle pulse, and err is 1 only together with done after a refused program.
- R10: fz_strobe and fz_load are high only while selected. fz_load is never high while programming. fz_addr is stable while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request, taken in idle only |
| req_prog | input | 1 | 1 = blow a fuse bit, 0 = read a byte |
| req_addr | input | 8 | Bit index (program) or byte in bits 7:3 (read) |
| key_wr | input | 1 | Writes the guard key |
| key_data | input | 8 | Key value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Program refused (guard locked) |
| rd_data | output | 8 | Last byte read |
| fz_csb_n | output | 1 | Array select, active low |
| fz_strobe | output | 1 | Array access strobe |
| fz_load | output | 1 | Sense-latch enable |
| fz_pgm_n | output | 1 | Program enable, active low |
| fz_addr | output | 8 | Array address |
| fz_q | input | 8 | Array data out |

## Verification
Several properties are checked on every cycle: the program pulse lasts exactly PGM_CYC cycles, the strobe has at least GAP_CYC cycles of select setup, and the strobe and sense-latch occur only while selected. The same per-cycle checks cover sense-latch exclusion during programming, address stability, the single-cycle done pulse and the pairing of err with done. Other behaviour can only be shown by the bench's scenarios against a behavioural array: that the correct bit gets blown, the byte value returned, the key lock and relock, refusal with zero pin activity, dropped requests while busy, and the end-to-end latencies.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_SEL,
        ST_RD_LOAD,
        ST_RD_STRB,
        ST_RD_CAPT,
        ST_PG_SEL,
        ST_PG_PULSE,
        ST_PG_HOLD,
        ST_FINISH,
        ST_REJECT
    } fz_state_e;

    typedef struct packed {
        logic csb_n;
        logic strobe;
        logic load;
        logic pgm_n;
    } fz_pins_t;

    localparam fz_pins_t PINS_PARKED = '{csb_n: 1'b1, strobe: 1'b0, load: 1'b0, pgm_n: 1'b1};

    function automatic fz_pins_t pins_for(fz_state_e st);
        fz_pins_t p;
        p = PINS_PARKED;
        unique case (st)
            ST_RD_SEL:   p.csb_n = 1'b0;
            ST_RD_LOAD:  begin p.csb_n = 1'b0; p.load = 1'b1; end
            ST_RD_STRB:  begin p.csb_n = 1'b0; p.load = 1'b1; p.strobe = 1'b1; end
            ST_RD_CAPT:  begin p.csb_n = 1'b0; p.load = 1'b1; end
            ST_PG_SEL:   begin p.csb_n = 1'b0; p.pgm_n = 1'b0; end
            ST_PG_PULSE: begin p.csb_n = 1'b0; p.pgm_n = 1'b0; p.strobe = 1'b1; end
            ST_PG_HOLD:  begin p.csb_n = 1'b0; p.pgm_n = 1'b0; end
            default:     p = PINS_PARKED;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/fuse_gap_timer.sv
module fuse_gap_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/fuse_key_lock.sv
module fuse_key_lock #(
    parameter int          KW  = 8,
    parameter logic [KW-1:0] KEY = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [KW-1:0] key_data,
    output logic          unlocked
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (key_wr)
            unlocked <= (key_data == KEY);
    end
endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
    import fuse_ctrl_pkg::*;
#(
    parameter int          CLK_MHZ = 250,
    parameter int          GAP_NS  = 20,
    parameter int          PGM_NS  = 10000,
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  KEY     = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_prog,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              key_wr,
    input  logic [7:0]        key_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              fz_csb_n,
    output logic              fz_strobe,
    output logic              fz_load,
    output logic              fz_pgm_n,
    output logic [ADDR_W-1:0] fz_addr,
    input  logic [DATA_W-1:0] fz_q
);
    localparam int GAP_CYC = (GAP_NS * CLK_MHZ + 999) / 1000;
    localparam int PGM_CYC = (PGM_NS * CLK_MHZ) / 1000;
    localparam int TW      = $clog2(PGM_CYC + 1);
    localparam int BSEL_W  = $clog2(DATA_W);
    localparam logic [TW-1:0] GAP_LD = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] PGM_LD = TW'(PGM_CYC - 1);

    fz_state_e     state, state_nx;
    logic          tmr_load, tmr_exp, unlocked;
    logic [TW-1:0] tmr_val;
    fz_pins_t      pins_nx;

    fuse_gap_timer #(.TW(TW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    fuse_key_lock #(.KW(8), .KEY(KEY)) lock_i (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data), .unlocked(unlocked)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = GAP_LD;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_prog) begin
                        state_nx = ST_RD_SEL;
                        tmr_load = 1'b1;
                    end else if (unlocked) begin
                        state_nx = ST_PG_SEL;
                        tmr_load = 1'b1;
                    end else begin
                        state_nx = ST_REJECT;
                    end
                end
            end
            ST_RD_SEL:   if (tmr_exp) begin state_nx = ST_RD_LOAD; tmr_load = 1'b1; end
            ST_RD_LOAD:  if (tmr_exp) begin state_nx = ST_RD_STRB; tmr_load = 1'b1; end
            ST_RD_STRB:  if (tmr_exp) begin state_nx = ST_RD_CAPT; tmr_load = 1'b1; end
            ST_RD_CAPT:  if (tmr_exp) state_nx = ST_FINISH;
            ST_PG_SEL: begin
                if (tmr_exp) begin
                    state_nx = ST_PG_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PGM_LD;
                end
            end
            ST_PG_PULSE: if (tmr_exp) begin state_nx = ST_PG_HOLD; tmr_load = 1'b1; end
            ST_PG_HOLD:  if (tmr_exp) state_nx = ST_FINISH;
            ST_FINISH,
            ST_REJECT:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Registered outputs, decoded from the next state
    assign pins_nx = pins_for(state_nx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fz_csb_n  <= 1'b1;
            fz_strobe <= 1'b0;
            fz_load   <= 1'b0;
            fz_pgm_n  <= 1'b1;
            fz_addr   <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            rd_data   <= '0;
        end else begin
            fz_csb_n  <= pins_nx.csb_n;
            fz_strobe <= pins_nx.strobe;
            fz_load   <= pins_nx.load;
            fz_pgm_n  <= pins_nx.pgm_n;
            busy      <= (state_nx != ST_IDLE);
            done      <= (state_nx == ST_FINISH) || (state_nx == ST_REJECT);
            err       <= (state_nx == ST_REJECT);
            if (state == ST_IDLE && state_nx == ST_RD_SEL)
                fz_addr <= {req_addr[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}};
            else if (state == ST_IDLE && state_nx == ST_PG_SEL)
                fz_addr <= req_addr;
            if (state == ST_RD_CAPT && tmr_exp)
                rd_data <= fz_q;
        end
    end
endmodule

// File: rtl/fuse_seq_ctrl_chk.sv
module fuse_seq_ctrl_chk #(
    parameter int GAP_CYC = 5,
    parameter int PGM_CYC = 2500,
    parameter int ADDR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              fz_csb_n,
    input logic              fz_strobe,
    input logic              fz_load,
    input logic              fz_pgm_n,
    input logic [ADDR_W-1:0] fz_addr
);
    localparam int CW = $clog2(PGM_CYC + 2);

    logic [CW-1:0] sel_cnt, pw_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || fz_csb_n)
            sel_cnt <= '0;
        else if (sel_cnt != {CW{1'b1}})
            sel_cnt <= sel_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || !fz_strobe)
            pw_cnt <= '0;
        else if (pw_cnt != {CW{1'b1}})
            pw_cnt <= pw_cnt + 1'b1;
    end

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fz_strobe) && !fz_pgm_n) |-> (pw_cnt == CW'(PGM_CYC)));

    p_strobe_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fz_strobe) |-> (sel_cnt >= CW'(GAP_CYC)));

    p_strobe_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fz_strobe || fz_load) |-> !fz_csb_n);

    p_load_not_pgm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fz_load |-> fz_pgm_n);

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fz_csb_n && $past(!fz_csb_n)) |-> $stable(fz_addr));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && fz_csb_n));

    p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fz_csb_n && !fz_strobe && !fz_load && fz_pgm_n));
endmodule

bind fuse_seq_ctrl fuse_seq_ctrl_chk #(
    .GAP_CYC(GAP_CYC), .PGM_CYC(PGM_CYC), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .fz_csb_n(fz_csb_n), .fz_strobe(fz_strobe), .fz_load(fz_load),
    .fz_pgm_n(fz_pgm_n), .fz_addr(fz_addr)
);

// File: tb/fuse_seq_ctrl_tb_top.sv
module fuse_seq_ctrl_tb_top;
    localparam int G = 5;
    localparam int P = 2500;
    localparam logic [7:0] KEYV = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_prog = 1'b0, key_wr = 1'b0;
    logic [7:0] req_addr = '0, key_data = '0;
    logic busy, done, err;
    logic [7:0] rd_data, fz_addr;
    logic fz_csb_n, fz_strobe, fz_load, fz_pgm_n;
    logic [7:0] fz_q;

    always #2 clk = ~clk;

    fuse_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
        .req_addr(req_addr), .key_wr(key_wr), .key_data(key_data),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .fz_csb_n(fz_csb_n), .fz_strobe(fz_strobe), .fz_load(fz_load),
        .fz_pgm_n(fz_pgm_n), .fz_addr(fz_addr), .fz_q(fz_q)
    );

    // Behavioural fuse array and pin monitor
    logic [255:0] fmem, refm;
    logic [7:0]   q_lat = '0;
    logic         st_prev = 1'b0, ld_prev = 1'b0;
    int           csb_cnt = 0, ld_cnt = 0, st_cnt = 0, act_cnt = 0;
    int           last_setup = 0, last_ld_gap = 0, last_pw = 0, last_ld_hold = 0;
    logic [7:0]   last_addr = '0;
    int           cmp = 0, bad = 0, cyc = 0;
    logic         unl = 1'b0;

    assign fz_q = q_lat;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!fz_csb_n) act_cnt <= act_cnt + 1;
        if (fz_strobe && !st_prev) begin
            last_setup = csb_cnt;
            last_ld_gap = ld_cnt;
            last_addr = fz_addr;
        end
        if (!fz_strobe && st_prev) begin
            last_pw = st_cnt;
            if (!fz_pgm_n && st_cnt >= 2250 && st_cnt <= 2750) fmem[last_addr] = 1'b1;
        end
        if (!fz_load && ld_prev) last_ld_hold = ld_cnt;
        if (!fz_csb_n && fz_load && fz_strobe && fz_pgm_n) q_lat <= fmem[fz_addr[7:3]*8 +: 8];
        csb_cnt = fz_csb_n ? 0 : csb_cnt + 1;
        st_cnt  = fz_strobe ? st_cnt + 1 : 0;
        ld_cnt  = (fz_load && !(fz_strobe && !st_prev)) ? ld_cnt + 1 : (fz_load ? 0 : ld_cnt);
        if (!fz_load && !ld_prev) ld_cnt = 0;
        st_prev = fz_strobe;
        ld_prev = fz_load;
    end

    function automatic logic [7:0] exp_byte(input logic [255:0] m, input logic [7:0] a);
        return m[a[7:3]*8 +: 8];
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        cmp++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        for (int i = 1; i < 4000; i++) begin
            @(negedge clk);
            if (done) begin lat = i; return; end
        end
    endtask

    task automatic pulse_req(input logic prog, input logic [7:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_prog = prog; req_addr = a;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic write_key(input logic [7:0] v);
        @(negedge clk);
        key_wr = 1'b1; key_data = v;
        @(negedge clk);
        key_wr = 1'b0;
        unl = (v == KEYV);
    endtask

    task automatic do_read(input logic [7:0] a);
        int lat;
        pulse_req(1'b0, a);
        wait_done(lat);
        chk("R2", "read latency", lat, 4*G+1);
        chk("R9", "err on read", err, 0);
        chk("R2", "read addr", last_addr, {a[7:3], 3'b000});
        chk("R2", "select setup before strobe", last_setup, 2*G);
        chk("R2", "sense-latch lead before strobe", last_ld_gap, G);
        chk("R7", "read byte", rd_data, exp_byte(refm, a));
        @(negedge clk);
        chk("R9", "done single cycle", done, 0);
        chk("R3", "rd_data held", rd_data, exp_byte(refm, a));
    endtask

    task automatic do_prog(input logic [7:0] a);
        int lat, act0;
        act0 = act_cnt;
        pulse_req(1'b1, a);
        wait_done(lat);
        if (unl) begin
            chk("R4", "program latency", lat, 2*G+P+1);
            chk("R4", "program pulse width", last_pw, P);
            chk("R4", "program setup", last_setup, G);
            chk("R4", "program addr", last_addr, a);
            chk("R9", "err on program", err, 0);
            refm[a] = 1'b1;
        end else begin
            chk("R6", "reject latency", lat, 1);
            chk("R6", "err on reject", err, 1);
            chk("R6", "no pin activity", act_cnt - act0, 0);
        end
        @(negedge clk);
        chk("R9", "done single cycle", done, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++;
        cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
        $finish;
    end

    initial begin : main
        int lat;
        logic [7:0] a;
        void'($urandom(32'h5EED_F00D));
        fmem = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        refm = fmem;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "csb_n in reset", fz_csb_n, 1);
        chk("R1", "pgm_n in reset", fz_pgm_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", done, 0);
        chk("R1", "rd_data after reset", rd_data, 0);
        chk("R1", "strobe/load after reset", {fz_strobe, fz_load}, 0);

        // Directed: reads locked, refused program at reset lock
        do_read(8'h00);
        do_read(8'hFF);
        do_prog(8'h13);                 // R6: locked at reset (R1)
        write_key(8'h5A);               // R5: wrong key keeps lock
        do_prog(8'h14);
        write_key(KEYV);                // R5: unlock
        do_prog(8'h00);
        do_prog(8'hFF);
        do_read(8'h00);
        do_read(8'hF8);
        write_key(8'h00);               // R5: relock
        do_prog(8'h20);
        do_read(8'h20);                 // R7: read while locked

        // R8: request while busy is ignored
        write_key(KEYV);
        refm[8'h47] = refm[8'h47];
        pulse_req(1'b0, 8'h80);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_prog = 1'b1; req_addr = 8'h47;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(lat);
        chk("R8", "first op completes", lat > 0, 1);
        begin
            int extra = 0;
            repeat (30) begin @(negedge clk); if (done || !fz_csb_n) extra++; end
            chk("R8", "no second op", extra, 0);
        end
        do_read(8'h47);
        chk("R8", "busy request did not program", fmem[8'h47], refm[8'h47]);

        // Constrained random mix
        for (int i = 0; i < 30; i++) begin
            int r;
            r = $urandom_range(0, 9);
            a = 8'($urandom);
            if (r < 5) do_read(a);
            else if (r < 8) do_prog(a);
            else write_key(($urandom_range(0, 1) == 1) ? KEYV : 8'($urandom));
        end
        for (int b = 0; b < 32; b++) do_read(8'(b * 8));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
        $finish;
    end
endmodule